// File: doc/BRIEF.md
# Microcoded I2C Waveform Sequencer

This block is an I2C master whose bus waveform comes from a small step memory rather than from a byte-level state machine. Each memory entry describes one step on the bus. An entry holds the SCL level and the SDA level for that step, a flag that samples SDA into a read register, a flag that marks the step as active, and the address of the entry that follows. Software fills the memory with a linked chain of steps. The chain covers the start condition, the address and data bits, the acknowledge slots, the read bits and the stop condition. Software then issues a go command.

Once started, the sequencer walks the chain at a rate set by a step divider. It drives SCL and SDA as open-drain pull-downs and stops at the first inactive entry it reaches. Entry 0 is the home entry: it is inactive, it normally points to itself, and its levels are both high. A run leaves the home entry and begins at entry 1. The chain ends by pointing back to 0. Bits sampled during the run collect in a 32-bit word, and the newest bit lands in bit 0.

Top module: `i2c_step_sequencer`

## Requirements
- R1: An entry write (`ent_we`) stores the entry at the slot given by `ent_wdata[27:18]`. Bit 13 is the active flag, bit 12 the sample flag, bit 11 the inverted SCL level, bit 10 the inverted SDA level, and bits 9:0 the next slot. The memory holds 1024 entries. A write issued while `seq_busy` is 1 is discarded.
- R2: A go command (`ctl_we` with `ctl_wdata[2]`=1) issued while idle sets `seq_busy` and clears `rd_word` to 0 on the next cycle. The run then begins at entry 1.
- R3: While running, one entry is applied every `step_div`+1 cycles. The first entry is applied `step_div`+1 cycles after the go edge. A run of N active entries keeps `seq_busy` high for (`step_div`+1)·(N+1) cycles.
- R4: Applying an entry sets each line to the inverse of its stored bit. The outputs are open-drain: `scl_low`/`sda_low` is 1 exactly when that line is driven low.
- R5: After an active entry is applied, the next step uses the entry named by that entry's next-slot field.
- R6: When an inactive entry is reached, its line levels are applied, `seq_busy` falls in the same cycle, and the lines then hold until the next run.
- R7: An active entry with the sample flag set and the SCL field high shifts the synchronised SDA value into `rd_word` bit 0 when it is applied. The older bits move up by one, so after a 4-byte read the last byte sits in bits 7:0. `rd_word` changes only through such shifts and through the clear on a go command.
- R8: SDA reaches the sampler through a 2-flop synchroniser. The bit captured at a step edge is the value `sda_in` held at the clock edge two cycles earlier.
- R9: A go command issued while `seq_busy` is 1 has no effect on the running chain or its length.
- R10: After reset both lines are released (`scl_low`=`sda_low`=0), `seq_busy` is 0 and `rd_word` is 0.
- R11: An entry with the sample flag set but the SCL field low does not change `rd_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_we | input | 1 | Step-entry write strobe |
| ent_wdata | input | 32 | Step-entry write word (slot, flags, levels, next slot) |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control word; bit 2 is the go command |
| step_div | input | 16 | Cycles per step minus one |
| sda_in | input | 1 | Sensed SDA line level (asynchronous) |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| seq_busy | output | 1 | 1 while a run is in progress |
| rd_word | output | 32 | Collected read bits, newest in bit 0 |

## Verification
The hardest situation to reach is the relationship between the synchroniser delay and the step that samples. A bad offset of one cycle only shows when `sda_in` changes within two cycles of a sampling step. The stimulus therefore toggles `sda_in` on every cycle from an LFSR during read chains at several divider values. A cycle-level model decides exactly which bit should land in `rd_word`. Attempts to change the chain or restart it while it runs are made mid-run, and the run length and the waveform still have to match the untouched chain.

// File: rtl/i2cseq_pkg.sv
// Package: field positions of the step-entry word and the control word,
// and the packed flag set stored per entry. Assumes a 32-bit write bus.
package i2cseq_pkg;

    localparam int WORD_W       = 32;
    localparam int FLD_SLOT_LSB = 18;
    localparam int FLD_ACTIVE   = 13;
    localparam int FLD_SAMPLE   = 12;
    localparam int FLD_SCL_N    = 11;
    localparam int FLD_SDA_N    = 10;
    localparam int CMD_GO_BIT   = 2;

    typedef struct packed {
        logic active;
        logic sample;
        logic scl_n;
        logic sda_n;
    } step_flags_t;

endpackage

// File: rtl/i2cseq_store.sv
// Step memory: DEPTH entries of flags plus next-slot pointer.
// Write port is gated by the caller; read port is combinational.
// Assumes DEPTH == 2**AW. Contents are not reset.
module i2cseq_store
    import i2cseq_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_slot,
    input  step_flags_t       wr_flags,
    input  logic [AW-1:0]     wr_next,
    input  logic [AW-1:0]     rd_slot,
    output step_flags_t       rd_flags,
    output logic [AW-1:0]     rd_next
);

    step_flags_t     flag_mem [DEPTH];
    logic [AW-1:0]   next_mem [DEPTH];

    // Capture an accepted entry write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            flag_mem[wr_slot] <= wr_flags;
            next_mem[wr_slot] <= wr_next;
        end
    end

    // Present the entry at the current slot.
    always_comb begin
        rd_flags = flag_mem[rd_slot];
        rd_next  = next_mem[rd_slot];
    end

endmodule

// File: rtl/i2cseq_pacer.sv
// Step pacer: while run is high, raises step once every div+1 cycles,
// the first one div+1 cycles after run rises. Counter idles at zero.
module i2cseq_pacer #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          step
);

    logic [DW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt >= div);
    assign step   = run && at_end;

    // Count cycles within a step, restarting at each step edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2cseq_sync.sv
// Multi-flop synchroniser for the sensed SDA line. Resets to 1
// (released line). STAGES must be at least 1.
module i2cseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One flop of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= 1'b1;
                end else begin
                    chain[g] <= (g == 0) ? d : chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/i2cseq_engine.sv
// Walk engine: holds the run flag, the current slot, the line levels
// and the read shift word. A go while idle starts at FIRST_SLOT; each
// step applies the current entry; an inactive entry ends the run.
module i2cseq_engine
    import i2cseq_pkg::*;
#(
    parameter int AW   = 10,
    parameter int RD_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            step,
    input  step_flags_t     cur_flags,
    input  logic [AW-1:0]   cur_next,
    input  logic            sda_s,
    output logic            running,
    output logic [AW-1:0]   slot,
    output logic            scl_lvl,
    output logic            sda_lvl,
    output logic [RD_W-1:0] shreg
);

    localparam logic [AW-1:0] HOME_SLOT  = '0;
    localparam logic [AW-1:0] FIRST_SLOT = AW'(1);

    logic take_bit;
    assign take_bit = cur_flags.active && cur_flags.sample && !cur_flags.scl_n;

    // Sequence control, line levels and sample shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            slot    <= HOME_SLOT;
            scl_lvl <= 1'b1;
            sda_lvl <= 1'b1;
            shreg   <= '0;
        end else if (go) begin
            running <= 1'b1;
            slot    <= FIRST_SLOT;
            shreg   <= '0;
        end else if (running && step) begin
            scl_lvl <= ~cur_flags.scl_n;
            sda_lvl <= ~cur_flags.sda_n;
            if (take_bit) begin
                shreg <= {shreg[RD_W-2:0], sda_s};
            end
            if (cur_flags.active) begin
                slot <= cur_next;
            end else begin
                running <= 1'b0;
                slot    <= HOME_SLOT;
            end
        end
    end

endmodule

// File: rtl/i2c_step_sequencer.sv
// Top: microcoded I2C master. Decodes entry and control writes,
// gates entry writes while running, and wires store, pacer,
// synchroniser and engine. Outputs are open-drain pull-down enables.
module i2c_step_sequencer #(
    parameter int DEPTH       = 1024,
    parameter int DIV_W       = 16,
    parameter int RD_W        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ent_we,
    input  logic [31:0]      ent_wdata,
    input  logic             ctl_we,
    input  logic [31:0]      ctl_wdata,
    input  logic [DIV_W-1:0] step_div,
    input  logic             sda_in,
    output logic             scl_low,
    output logic             sda_low,
    output logic             seq_busy,
    output logic [RD_W-1:0]  rd_word
);
    import i2cseq_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam logic [31:0] ENT_USED =
        ({{(32-AW){1'b0}}, {AW{1'b1}}} << FLD_SLOT_LSB) |
        (32'h1 << FLD_ACTIVE) | (32'h1 << FLD_SAMPLE) |
        (32'h1 << FLD_SCL_N) | (32'h1 << FLD_SDA_N) |
        {{(32-AW){1'b0}}, {AW{1'b1}}};

    logic           running;
    logic           go;
    logic           step;
    logic           wr_en;
    step_flags_t    wr_flags;
    step_flags_t    cur_flags;
    logic [AW-1:0]  wr_slot;
    logic [AW-1:0]  wr_next;
    logic [AW-1:0]  cur_next;
    logic [AW-1:0]  slot;
    logic           sda_s;
    logic           scl_lvl;
    logic           sda_lvl;
    logic           unused_bits;

    // Decode the write ports.
    always_comb begin
        go              = ctl_we && ctl_wdata[CMD_GO_BIT] && !running;
        wr_en           = ent_we && !running;
        wr_slot         = ent_wdata[FLD_SLOT_LSB +: AW];
        wr_next         = ent_wdata[AW-1:0];
        wr_flags.active = ent_wdata[FLD_ACTIVE];
        wr_flags.sample = ent_wdata[FLD_SAMPLE];
        wr_flags.scl_n  = ent_wdata[FLD_SCL_N];
        wr_flags.sda_n  = ent_wdata[FLD_SDA_N];
    end

    assign unused_bits = ^(ent_wdata & ~ENT_USED) ^
                         ^(ctl_wdata & ~(32'h1 << CMD_GO_BIT));

    i2cseq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_flags (wr_flags),
        .wr_next  (wr_next),
        .rd_slot  (slot),
        .rd_flags (cur_flags),
        .rd_next  (cur_next)
    );

    i2cseq_pacer #(.DW(DIV_W)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .div   (step_div),
        .step  (step)
    );

    i2cseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sda_in),
        .q     (sda_s)
    );

    i2cseq_engine #(.AW(AW), .RD_W(RD_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .step      (step),
        .cur_flags (cur_flags),
        .cur_next  (cur_next),
        .sda_s     (sda_s),
        .running   (running),
        .slot      (slot),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .shreg     (rd_word)
    );

    assign scl_low  = ~scl_lvl;
    assign sda_low  = ~sda_lvl;
    assign seq_busy = running;

endmodule

// File: rtl/i2cseq_checker.sv
// Checker for i2c_step_sequencer, bound to every instance of the top.
// Observes ports only.
module i2cseq_checker #(
    parameter int DIV_W = 16,
    parameter int RD_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [31:0]      ctl_wdata,
    input logic [DIV_W-1:0] step_div,
    input logic             scl_low,
    input logic             sda_low,
    input logic             seq_busy,
    input logic [RD_W-1:0]  rd_word
);

    logic go_req;
    assign go_req = ctl_we && ctl_wdata[2];

    assert_go_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && !seq_busy) |=> (seq_busy && rd_word == '0));

    assert_idle_lines_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy |=> ($stable(scl_low) && $stable(sda_low)));

    assert_idle_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && !go_req) |=> $stable(rd_word));

    assert_run_word_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> ((rd_word == $past(rd_word)) ||
                      (rd_word[RD_W-1:1] == $past(rd_word[RD_W-2:0]))));

    // Outputs must be defined once out of reset (R4).
    always @(posedge clk) begin
        if (rst_n) begin
            assert_known_outputs_R4: assert (!$isunknown({scl_low, sda_low, seq_busy}));
        end
    end

endmodule

bind i2c_step_sequencer i2cseq_checker #(.DIV_W(DIV_W), .RD_W(RD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .step_div  (step_div),
    .scl_low   (scl_low),
    .sda_low   (sda_low),
    .seq_busy  (seq_busy),
    .rd_word   (rd_word)
);

// File: tb/tb_i2c_step_sequencer.sv
module tb_i2c_step_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ent_we = 1'b0;
    logic [31:0] ent_wdata = '0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [15:0] step_div = '0;
    logic        sda_in = 1'b1;
    logic        scl_low, sda_low, seq_busy;
    logic [31:0] rd_word;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    string phase = "R10";

    always #10 clk = ~clk;

    i2c_step_sequencer dut (
        .clk(clk), .rst_n(rst_n), .ent_we(ent_we), .ent_wdata(ent_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .step_div(step_div),
        .sda_in(sda_in), .scl_low(scl_low), .sda_low(sda_low),
        .seq_busy(seq_busy), .rd_word(rd_word)
    );

    // ---------------- behavioural reference ----------------
    int          m_ent [1024];
    int          m_busy, m_slot, m_cnt, m_scl, m_sda, m_s1, m_s2;
    logic [31:0] m_rd;
    bit          model_on = 0;

    always @(posedge clk) begin
        int s2_old, e, idx;
        if (!rst_n) begin
            m_busy = 0; m_slot = 0; m_cnt = 0; m_scl = 1; m_sda = 1;
            m_s1 = 1; m_s2 = 1; m_rd = 0; model_on = 1;
        end else begin
            s2_old = m_s2; m_s2 = m_s1; m_s1 = int'(sda_in);
            if (ent_we && m_busy == 0) begin
                idx = int'((ent_wdata >> 18) & 32'h3ff);
                m_ent[idx] = int'(ent_wdata & 32'h3fff);
            end
            if (ctl_we && ctl_wdata[2] && m_busy == 0) begin
                m_busy = 1; m_slot = 1; m_rd = 0; m_cnt = 0;
            end else if (m_busy != 0) begin
                if (m_cnt >= int'(step_div)) begin
                    e = m_ent[m_slot];
                    m_cnt = 0;
                    m_scl = ((e >> 11) & 1) ^ 1;
                    m_sda = ((e >> 10) & 1) ^ 1;
                    if (((e >> 13) & 1) != 0) begin
                        if (((e >> 12) & 1) != 0 && ((e >> 11) & 1) == 0)
                            m_rd = {m_rd[30:0], s2_old[0]};
                        m_slot = e & 32'h3ff;
                    end else begin
                        m_busy = 0; m_slot = 0;
                    end
                end else begin
                    m_cnt++;
                end
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (model_on && !finished) begin
            compared++;
            if (scl_low !== (m_scl == 0) || sda_low !== (m_sda == 0) ||
                seq_busy !== (m_busy != 0) || rd_word !== m_rd) begin
                mismatched++;
                $display("FAIL %s cycle: act scl_low=%b sda_low=%b busy=%b rd=%h exp scl_low=%b sda_low=%b busy=%b rd=%h",
                         phase, scl_low, sda_low, seq_busy, rd_word,
                         m_scl == 0, m_sda == 0, m_busy != 0, m_rd);
            end
        end
    end

    // SDA source: 0 = hold low, 1 = hold high, 2 = LFSR every cycle.
    int      sda_mode = 1;
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sda_in = (sda_mode == 2) ? lfsr[0] : (sda_mode == 1);
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- chain builder ----------------
    int cur;

    task automatic put(input int s, input int act, input int smp, input int scl, input int sda, input int nxt);
        @(negedge clk);
        ent_we = 1'b1;
        ent_wdata = (s << 18) | (act << 13) | (smp << 12) | ((scl ^ 1) << 11) |
                    ((sda ^ 1) << 10) | (nxt & 32'h3ff);
        @(negedge clk);
        ent_we = 1'b0;
    endtask

    task automatic wbit(input int d);
        put(cur, 1, 0, 0, d, cur + 1);
        put(cur + 1, 1, 0, 1, d, cur + 2);
        put(cur + 2, 1, 0, 0, d, cur + 3);
        cur += 3;
    endtask

    task automatic rbit();
        put(cur, 1, 0, 0, 1, cur + 1);
        put(cur + 1, 1, 0, 1, 1, cur + 2);
        put(cur + 2, 1, 1, 1, 1, cur + 3);
        put(cur + 3, 1, 0, 0, 1, cur + 4);
        cur += 4;
    endtask

    // Build a chain: start, address byte + ack, nrd read bytes, stop.
    // Returns the number of active entries.
    task automatic build(input int addr_byte, input int nrd, output int nact);
        put(0, 0, 0, 1, 1, 0);
        cur = 1;
        put(cur, 1, 0, 1, 1, cur + 1);
        put(cur + 1, 1, 0, 1, 0, cur + 2);
        put(cur + 2, 1, 0, 0, 0, cur + 3);
        cur += 3;
        for (int i = 7; i >= 0; i--) wbit((addr_byte >> i) & 1);
        wbit(1);
        for (int b = 0; b < nrd; b++) begin
            for (int i = 0; i < 8; i++) rbit();
            wbit(b == nrd - 1);
        end
        put(cur, 1, 0, 0, 0, cur + 1);
        put(cur + 1, 1, 0, 1, 0, cur + 2);
        put(cur + 2, 1, 0, 1, 1, 0);
        cur += 3;
        nact = cur - 1;
    endtask

    // Issue go and count busy cycles; optional mid-run poke.
    // poke: 0 none, 1 second go, 2 overwrite entry 2 and entry 0.
    task automatic run(input int poke, output int busy_cycles);
        int n = 0;
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 32'h4;
        @(negedge clk);
        ctl_we = 1'b0; ctl_wdata = '0;
        check(seq_busy === 1'b1 && rd_word === 32'h0, "R2 go", {seq_busy, rd_word}, 64'h1_0000_0000);
        while (seq_busy === 1'b1 && n < 20000) begin
            n++;
            if (n == 7 && poke == 1) begin ctl_we = 1'b1; ctl_wdata = 32'h4; end
            else if (n == 7 && poke == 2) begin
                ent_we = 1'b1;
                ent_wdata = (2 << 18) | (1 << 13) | (0 << 11) | (1 << 10) | 3;
            end else if (n == 8 && poke == 2) begin
                ent_wdata = (0 << 18) | (1 << 13) | 0;
            end else begin
                ctl_we = 1'b0; ent_we = 1'b0;
            end
            @(negedge clk);
        end
        ctl_we = 1'b0; ent_we = 1'b0;
        busy_cycles = n;
    endtask

    int nact, bc;

    initial begin
        repeat (4) @(negedge clk);
        phase = "R10";
        check(scl_low === 1'b0 && sda_low === 1'b0, "R10 lines", {scl_low, sda_low}, 0);
        check(seq_busy === 1'b0 && rd_word === 32'h0, "R10 busy/word", {seq_busy, rd_word}, 0);
        rst_n = 1'b1;

        // Write byte then read one byte with SDA held high.
        phase = "R1 R4 R5"; sda_mode = 1; step_div = 0;
        build(8'hA5, 1, nact);
        phase = "R7 R5 R4";
        run(0, bc);
        check(bc == (nact + 1), "R3 div0 length", bc, nact + 1);
        check(rd_word === 32'hFF, "R7 one byte", rd_word, 32'hFF);
        check(scl_low === 1'b0 && sda_low === 1'b0, "R6 home levels", {scl_low, sda_low}, 0);

        // Divider 3, random SDA: exercises the synchroniser offset.
        phase = "R8 R3"; sda_mode = 2; step_div = 3;
        run(0, bc);
        check(bc == 4 * (nact + 1), "R3 div3 length", bc, 4 * (nact + 1));

        // Four bytes high, different divider.
        phase = "R7"; sda_mode = 1; step_div = 1;
        build(8'h3C, 4, nact);
        run(0, bc);
        check(rd_word === 32'hFFFFFFFF, "R7 four bytes", rd_word, 32'hFFFFFFFF);
        check(bc == 2 * (nact + 1), "R3 div1 length", bc, 2 * (nact + 1));

        // Random SDA on the 4-byte read at divider 0 and 2.
        phase = "R8"; sda_mode = 2; step_div = 0;
        run(0, bc);
        step_div = 2;
        run(0, bc);

        // Go while running is ignored.
        phase = "R9"; sda_mode = 1; step_div = 0;
        run(1, bc);
        check(bc == nact + 1, "R9 length with second go", bc, nact + 1);

        // Entry writes while running are discarded.
        phase = "R1";
        run(2, bc);
        check(bc == nact + 1, "R1 length with mid-run write", bc, nact + 1);
        run(0, bc);
        check(bc == nact + 1, "R1 chain unchanged", bc, nact + 1);
        check(rd_word === 32'hFFFFFFFF, "R1 reads unchanged", rd_word, 32'hFFFFFFFF);

        // Chain with no reads clears the word (R2), sample flag with SCL low (R11).
        phase = "R2";
        build(8'h81, 0, nact);
        run(0, bc);
        check(rd_word === 32'h0, "R2 cleared word", rd_word, 0);
        phase = "R11";
        put(0, 0, 0, 1, 1, 0);
        put(1, 1, 1, 0, 1, 2);
        put(2, 1, 1, 0, 0, 3);
        put(3, 1, 0, 1, 1, 0);
        run(0, bc);
        check(rd_word === 32'h0, "R11 no sample at SCL low", rd_word, 0);
        check(bc == 4, "R5 short chain length", bc, 4);

        // Idle: SDA changes cause no line or word change.
        phase = "R6"; sda_mode = 2;
        repeat (20) @(negedge clk);
        check(scl_low === 1'b0 && sda_low === 1'b0 && rd_word === 32'h0, "R6 idle hold",
              {scl_low, sda_low, rd_word}, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog %s: act=hung exp=done", phase);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule